// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns the 1-bit output of a delta-sigma modulator into decimated multi-bit words. It runs on the modulator clock and takes one data bit on each clock. A bit of 1 counts as +1 and a bit of 0 counts as -1. Cascaded integrators run at the full rate. After every window of samples, a comb chain works out one decimated result. The filter order is chosen at run time, and so is the window length, which runs from 1 to 256 samples.

The configuration arrives as plain synchronous inputs: a 2-bit mode, an enable, an acknowledge enable and an 8-bit ratio code. Turning the enable off clears the whole datapath. Changing the mode or the ratio code also clears the whole datapath. Each new result comes with a one-clock valid strobe. A sticky acknowledge flag can record that a result arrived, and software clears that flag through a separate input. The results carry full precision, so the sinc3 response at a ratio of 256 never wraps.

Top module: `sinc_decim`

## Requirements
- R1: The mode input selects the structure. Mode 2'b01 gives sinc1 and mode 2'b10 gives sinc2. Mode 2'b11 gives sinc3. Mode 2'b00 is the fast structure, which is a sinc2 response. With the bit mapping 1 → +1 and 0 → -1, each result is the order-N cascade of N moving sums of length R, taken at the last sample of the window.
- R2: The window length R is the ratio code plus one. A result falls due after every R accepted samples.
- R3: While the enable is 0, no valid strobe appears. All accumulators, comb delays and counters are held at zero, so the first window after re-enable starts with the next sample.
- R4: For sinc1, sinc2 and sinc3, the first N-1 results after a restart are suppressed, where N is the order. The fast structure suppresses none.
- R5: A clock edge on which the mode or the ratio code differs from its value at the previous edge restarts the filter, as in R3. The sample on that edge is discarded.
- R6: valid_o is high for exactly one clock per window. With a ratio code of 0, a result is due on every clock, so valid_o can stay high.
- R7: If ack_en_i is 1 on the edge that produces a result, ack_o goes to 1 on that same edge. ack_o stays at 1 until an edge with ack_clr_i high and no new result to set it. When a result is being set on the same edge as a clear, the set wins.
- R8: If ack_en_i is 0, a result leaves ack_o unchanged.
- R9: In reset, valid_o and ack_o are 0 and the stored configuration is zero.
- R10: With sinc3, a ratio code of 0xFF and a constant bit, the result reaches exactly +2^24 or -2^24 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Modulator data bit |
| mode_i | input | 2 | Structure select (00 fast, 01 sinc1, 10 sinc2, 11 sinc3) |
| en_i | input | 1 | Filter enable |
| ack_en_i | input | 1 | Enables setting of the acknowledge flag |
| ratio_i | input | 8 | Ratio code; window length is code+1 |
| ack_clr_i | input | 1 | Clears the acknowledge flag |
| result_o | output | 26 | Signed filter result, held between strobes |
| valid_o | output | 1 | One-clock strobe for a new result |
| ack_o | output | 1 | Sticky acknowledge flag |

## Verification
Each mode is run at ratio codes 0, 1, 3, 15 and 255. The test streams are all ones, all zeros, alternating bits, a three-in-four density and a pseudo-random sequence. The constant streams pin the full-scale gain and the sign mapping. The alternating and dense streams separate the three orders through their triangular and cubic weighting. The pseudo-random stream catches off-by-one errors in the window boundary. Further runs disable the filter mid-window, change the ratio mid-window, collide a clear with a strobe and run with the acknowledge turned off. These runs separate the restart, the discard and the flag logic.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;
  typedef enum logic [1:0] {
    MODE_FAST  = 2'b00,
    MODE_SINC1 = 2'b01,
    MODE_SINC2 = 2'b10,
    MODE_SINC3 = 2'b11
  } mode_e;

  function automatic logic [1:0] order_of(mode_e m);
    return (m == MODE_FAST) ? 2'd2 : 2'(m);
  endfunction

  function automatic logic [1:0] settle_of(mode_e m);
    return (m == MODE_FAST) ? 2'd0 : 2'(m) - 2'd1;
  endfunction
endpackage

// File: rtl/sinc_decim_ctrl.sv
module sinc_decim_ctrl #(
  parameter int RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [1:0]         settle_i,
  output logic               dump_o,
  output logic               emit_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic [1:0]         disc_q;

  assign dump_o = !restart_i && (cnt_q == ratio_i);
  assign emit_o = dump_o && (disc_q >= settle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      disc_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      disc_q <= '0;
    end else if (dump_o) begin
      cnt_q <= '0;
      if (disc_q < settle_i) disc_q <= disc_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sinc_decim_integ.sv
module sinc_decim_integ #(
  parameter int ACC_W  = 26,
  parameter int STAGES = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          bit_i,
  output logic [STAGES-1:0][ACC_W-1:0]  sum_o
);
  logic [STAGES-1:0][ACC_W-1:0] acc_q;
  logic [ACC_W-1:0]             x;

  assign x = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sum_o[g] = acc_q[g] + x;
    end else begin : g_next
      assign sum_o[g] = acc_q[g] + sum_o[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q[g] <= '0;
      else if (clr_i) acc_q[g] <= '0;
      else            acc_q[g] <= sum_o[g];
    end
  end
endmodule

// File: rtl/sinc_decim_comb.sv
module sinc_decim_comb #(
  parameter int ACC_W  = 26,
  parameter int STAGES = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          dump_i,
  input  logic [ACC_W-1:0]              din_i,
  output logic [STAGES-1:0][ACC_W-1:0]  dout_o
);
  logic [STAGES-1:0][ACC_W-1:0] dly_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [ACC_W-1:0] stage_in;
    if (g == 0) begin : g_first
      assign stage_in = din_i;
    end else begin : g_next
      assign stage_in = dout_o[g-1];
    end
    assign dout_o[g] = stage_in - dly_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dly_q[g] <= '0;
      else if (clr_i)    dly_q[g] <= '0;
      else if (dump_i)   dly_q[g] <= stage_in;
    end
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_decim_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int ACC_W   = 3 * RATIO_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_i,
  input  logic [1:0]         mode_i,
  input  logic               en_i,
  input  logic               ack_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ack_clr_i,
  output logic [ACC_W-1:0]   result_o,
  output logic               valid_o,
  output logic               ack_o
);
  localparam int STAGES = 3;

  mode_e                        mode, mode_q;
  logic [RATIO_W-1:0]           ratio_q;
  logic                         restart, dump, emit;
  logic [1:0]                   sel;
  logic [STAGES-1:0][ACC_W-1:0] integ_sum, comb_out;

  assign mode    = mode_e'(mode_i);
  assign restart = !en_i || (mode != mode_q) || (ratio_i != ratio_q);
  assign sel     = order_of(mode) - 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_FAST;
      ratio_q <= '0;
    end else begin
      mode_q  <= mode;
      ratio_q <= ratio_i;
    end
  end

  sinc_decim_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .ratio_i  (ratio_i),
    .settle_i (settle_of(mode)),
    .dump_o   (dump),
    .emit_o   (emit)
  );

  sinc_decim_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .bit_i (bit_i),
    .sum_o (integ_sum)
  );

  sinc_decim_comb #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .dump_i(dump),
    .din_i (integ_sum[sel]),
    .dout_o(comb_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      valid_o <= emit;
      if (emit) result_o <= comb_out[sel];
      if (emit && ack_en_i) ack_o <= 1'b1;
      else if (ack_clr_i)   ack_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int RATIO_W = 8,
  parameter int ACC_W   = 3 * RATIO_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               ack_en_i,
  input logic               ack_clr_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [ACC_W-1:0]   result_o,
  input logic               valid_o,
  input logic               ack_o
);
  localparam logic signed [ACC_W-1:0] FULL = ACC_W'(longint'(1) << (3 * RATIO_W));

  logic signed [ACC_W-1:0] res_s;
  assign res_s = $signed(result_o);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  // R6
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ratio_i != '0) |=> !valid_o);

  // R7
  ack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ack_en_i)) |-> ack_o);

  // R7
  ack_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_clr_i) |=> ack_o);

  // R8
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> (valid_o && $past(ack_en_i)));

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (res_s <= FULL && res_s >= -FULL));
endmodule

bind sinc_decim sinc_decim_chk #(.RATIO_W(RATIO_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .ack_en_i (ack_en_i),
  .ack_clr_i(ack_clr_i),
  .ratio_i  (ratio_i),
  .result_o (result_o),
  .valid_o  (valid_o),
  .ack_o    (ack_o)
);

// File: tb/tb_sinc_decim.sv
module tb_sinc_decim;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        en_i = 1'b0;
  logic        ack_en_i = 1'b0;
  logic [7:0]  ratio_i = 8'd0;
  logic        ack_clr_i = 1'b0;
  logic [25:0] result_o;
  logic        valid_o;
  logic        ack_o;

  int vecs = 0;
  int errs = 0;

  // reference model state
  int      xq[$], s1q[$], s2q[$];
  int      m_cnt, m_nout;
  logic [1:0] m_pmode;
  logic [7:0] m_pratio;
  logic    e_valid, e_ack;
  int      e_res;
  logic [15:0] lfsr = 16'hACE1;

  sinc_decim dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .mode_i(mode_i),
    .en_i(en_i), .ack_en_i(ack_en_i), .ratio_i(ratio_i), .ack_clr_i(ack_clr_i),
    .result_o(result_o), .valid_o(valid_o), .ack_o(ack_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int qsum(ref int q[$]);
    int s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  function automatic void model_clear();
    xq.delete(); s1q.delete(); s2q.delete();
    m_cnt = 0; m_nout = 0;
  endfunction

  task automatic model_step();
    int r, s1, s2, s3, ord, disc, v;
    logic restart;
    r = int'(ratio_i) + 1;
    restart = !en_i || (mode_i != m_pmode) || (ratio_i != m_pratio);
    m_pmode = mode_i; m_pratio = ratio_i;
    e_valid = 1'b0;
    if (restart) model_clear();
    else begin
      xq.push_back(bit_i ? 1 : -1);   if (xq.size() > r) void'(xq.pop_front());
      s1 = qsum(xq);  s1q.push_back(s1); if (s1q.size() > r) void'(s1q.pop_front());
      s2 = qsum(s1q); s2q.push_back(s2); if (s2q.size() > r) void'(s2q.pop_front());
      s3 = qsum(s2q);
      m_cnt++;
      if (m_cnt == r) begin
        m_cnt = 0;
        ord  = (mode_i == 2'b00) ? 2 : int'(mode_i);
        disc = (mode_i == 2'b00) ? 0 : int'(mode_i) - 1;
        v = (ord == 1) ? s1 : (ord == 2) ? s2 : s3;
        if (m_nout >= disc) begin
          e_valid = 1'b1; e_res = v;
        end else m_nout++;
      end
    end
    if (e_valid && ack_en_i) e_ack = 1'b1;
    else if (ack_clr_i)      e_ack = 1'b0;
  endtask

  task automatic check(string tag);
    vecs++;
    if (valid_o !== e_valid) begin
      errs++; $display("FAIL %s valid: got %0b exp %0b", tag, valid_o, e_valid);
    end
    vecs++;
    if (ack_o !== e_ack) begin
      errs++; $display("FAIL %s ack: got %0b exp %0b", tag, ack_o, e_ack);
    end
    if (e_valid) begin
      vecs++;
      if (int'($signed(result_o)) != e_res) begin
        errs++; $display("FAIL %s result: got %0d exp %0d", tag, $signed(result_o), e_res);
      end
    end
  endtask

  function automatic logic next_bit(int pat, int n);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return n[0];
      3: return (n % 4) != 0;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
    endcase
  endfunction

  task automatic cyc(string tag);
    model_step();
    @(posedge clk_i); #1;
    check(tag);
  endtask

  task automatic run(logic [1:0] m, logic [7:0] rt, int pat, int n, string tag);
    mode_i = m; ratio_i = rt; en_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit_i = next_bit(pat, i);
      cyc(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int ratios[5] = '{0, 1, 3, 15, 255};
    m_pmode = 2'b00; m_pratio = 8'd0; e_ack = 1'b0; e_valid = 1'b0; e_res = 0;
    model_clear();
    #(CLK_PERIOD * 3 + 2);
    // R9 reset state
    vecs++;
    if (valid_o !== 1'b0 || ack_o !== 1'b0) begin
      errs++; $display("FAIL R9 reset: got valid=%0b ack=%0b exp 0 0", valid_o, ack_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    // R3 disabled after reset: no output
    for (int i = 0; i < 5; i++) begin bit_i = 1'b1; cyc("R3"); end

    // R1 R2 R4 R6: all modes, ratios and patterns
    ack_en_i = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++)
        run(2'(m), 8'(ratios[k]), (m + k) % 5, 5 * (ratios[k] + 1) + 6, "R1");

    // R10 full scale both signs
    run(2'b11, 8'hFF, 0, 4 * 256 + 2, "R10");
    en_i = 1'b0; cyc("R3");
    run(2'b11, 8'hFF, 1, 4 * 256 + 2, "R10");

    // R3 disable mid-window, then resume
    run(2'b10, 8'd7, 4, 13, "R3");
    en_i = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R3");
    run(2'b10, 8'd7, 4, 40, "R3");

    // R5 ratio and mode change mid-window
    run(2'b11, 8'd5, 3, 20, "R5");
    run(2'b11, 8'd6, 3, 30, "R5");
    run(2'b01, 8'd6, 2, 17, "R5");
    run(2'b00, 8'd4, 4, 17, "R4");

    // R7 clear, and set winning over clear
    ack_clr_i = 1'b1; cyc("R7"); ack_clr_i = 1'b0;
    for (int i = 0; i < 6; i++) cyc("R7");
    run(2'b01, 8'd0, 4, 1, "R7");
    ack_clr_i = 1'b1; cyc("R7"); cyc("R7"); ack_clr_i = 1'b0;

    // R8 ack disabled: flag must stay low through results
    ack_clr_i = 1'b1; run(2'b01, 8'd3, 4, 2, "R8"); ack_clr_i = 1'b0;
    ack_en_i = 1'b0;
    run(2'b01, 8'd3, 4, 30, "R8");
    run(2'b00, 8'd2, 2, 30, "R8");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule